// File: doc/BRIEF.md
# Cyclic-Shift Code Symbol Spreader

This block turns data symbols into serial spreading-chip streams for a direct-sequence transmitter. In long mode a 4-bit symbol selects one of sixteen 16-chip sequences. In short mode a 3-bit symbol selects one of eight 8-chip sequences. No code table is stored. Each sequence is built when its symbol is accepted, from a single root word held in a configuration input. The root may first have every odd-indexed chip inverted, and it is then rotated right by an even number of chips.

Symbols arrive on a valid/ready handshake. Chips leave one per chip-enable pulse, and a marker flags the first chip of each symbol. An optional cyclic-prefix chip repeats the sequence's last chip ahead of chip 0. The next symbol is taken in the same chip slot that follows the final chip of the current one, so the stream has no gaps while data is available. Root, mode and prefix setting take effect only when a symbol is accepted.

Top module: `cobi_spreader`

## Requirements
- R1: While rst_ni is low, chip_o, chip_valid_o and sym_start_o are 0. With no symbol in progress, sym_ready_o equals chip_en_i.
- R2: In long mode (short_mode_i=0), symbol 0 sends the long root with chip i taken from root bit 15-i, chip 0 first. With root 0x3AFC this gives 0011101011111100.
- R3: In long mode, symbol k with k<8 sends the symbol-0 sequence rotated right by 2k chips. Rotating right by one chip moves the last chip to position 0.
- R4: In long mode, symbol k with k>=8 first inverts every odd-indexed chip of the root, counting chip 0 as even. It then rotates that word right by 2(k-8) chips.
- R5: In short mode (short_mode_i=1), only sym_i[2:0] is used and sym_i[3] is ignored. The 8-bit short root is read with chip i from bit 7-i. sym_i[2] selects the odd-chip inversion, and the rotation is 2*sym_i[1:0] chips.
- R6: With prefix_en_i=1, each symbol is 17 chips (long) or 9 chips (short) long. The first of these chips is a copy of the last chip of the sequence.
- R7: The block sends exactly one chip for each chip_en_i pulse. Without a pulse, chip_o, chip_valid_o and sym_start_o hold their values. Each output appears one clock after the enabled edge.
- R8: sym_ready_o is 1 only while chip_en_i is 1 and the previous symbol's final chip has already been sent. Back-to-back symbols leave no empty chip slot.
- R9: sym_start_o is 1 only with the first chip of a symbol, which is the prefix chip when the prefix is enabled.
- R10: An enabled chip slot that starts no symbol and continues none gives chip_valid_o=0, sym_start_o=0 and chip_o=0.
- R11: The root words, short_mode_i and prefix_en_i are sampled when a symbol is accepted. Changing them in the middle of a symbol leaves that symbol's chips unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Chip-rate strobe; one chip is sent per pulse |
| sym_valid_i | input | 1 | A symbol is offered |
| sym_i | input | 4 | Symbol index; sym_i[0] is the first bit received |
| sym_ready_o | output | 1 | The symbol is taken at this edge if valid |
| short_mode_i | input | 1 | 0: 16-chip mode, 1: 8-chip mode |
| prefix_en_i | input | 1 | Add the one-chip cyclic prefix |
| root_long_i | input | 16 | Root word for 16-chip mode |
| root_short_i | input | 8 | Root word for 8-chip mode |
| chip_o | output | 1 | Current chip |
| chip_valid_o | output | 1 | chip_o carries a chip |
| sym_start_o | output | 1 | chip_o is the first chip of a symbol |

## Verification
sym_ready_o is combinational, so it is checked one time unit after the inputs for a slot are driven and before the edge. chip_o, chip_valid_o and sym_start_o take their new values at the enabled edge, one register stage later. They are checked one time unit after that edge against a chip queue the model fills when it accepts a symbol. On cycles without chip_en_i the model keeps its previous expectation, so the same comparison checks that the outputs hold.

// File: rtl/cobi_pkg.sv
package cobi_pkg;
  localparam int unsigned LONG_CHIPS  = 16;
  localparam int unsigned SHORT_CHIPS = 8;
  localparam int unsigned SYM_W       = $clog2(LONG_CHIPS);
  localparam int unsigned FRAME_W     = LONG_CHIPS + 1;
  localparam int unsigned LEN_W       = $clog2(FRAME_W + 1);
endpackage

// File: rtl/cobi_seq_gen.sv
// Builds one sequence: optional odd-chip inversion, then right rotation by 2*index.
module cobi_seq_gen #(
  parameter int unsigned N  = 16,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [N-1:0]  root_i,
  input  logic [SW-1:0] sym_i,
  output logic [N-1:0]  seq_o
);
  logic [N-1:0]  odd_mask;
  logic [N-1:0]  base;
  logic [SW-1:0] rot;

  // chip g sits at bit N-1-g; odd chips get inverted
  for (genvar g = 0; g < N; g++) begin : g_mask
    assign odd_mask[N-1-g] = (g % 2) == 1;
  end

  assign base  = root_i ^ (sym_i[SW-1] ? odd_mask : '0);
  assign rot   = {sym_i[SW-2:0], 1'b0};
  assign seq_o = (base >> rot) | (base << (N - int'(rot)));
endmodule

// File: rtl/cobi_frame_ctrl.sv
// Chip serializer: holds the frame, sends one chip per enable, takes the next symbol when empty.
module cobi_frame_ctrl #(
  parameter int unsigned FW = 17,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chip_en_i,
  input  logic          sym_valid_i,
  input  logic [FW-1:0] frame_i,
  input  logic [CW-1:0] len_i,
  output logic          sym_ready_o,
  output logic          chip_o,
  output logic          chip_valid_o,
  output logic          sym_start_o
);
  logic [FW-1:0] frame_q;
  logic [CW-1:0] rem_q;

  assign sym_ready_o = chip_en_i && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q      <= '0;
      rem_q        <= '0;
      chip_o       <= 1'b0;
      chip_valid_o <= 1'b0;
      sym_start_o  <= 1'b0;
    end else if (chip_en_i) begin
      if (rem_q != '0) begin
        chip_o       <= frame_q[FW-1];
        frame_q      <= frame_q << 1;
        rem_q        <= rem_q - 1'b1;
        chip_valid_o <= 1'b1;
        sym_start_o  <= 1'b0;
      end else if (sym_valid_i) begin
        chip_o       <= frame_i[FW-1];
        frame_q      <= frame_i << 1;
        rem_q        <= len_i - 1'b1;
        chip_valid_o <= 1'b1;
        sym_start_o  <= 1'b1;
      end else begin
        chip_o       <= 1'b0;
        chip_valid_o <= 1'b0;
        sym_start_o  <= 1'b0;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |=> ($stable(chip_o) && $stable(chip_valid_o) && $stable(sym_start_o)));
  p_ready_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_ready_o |-> chip_en_i);
  p_gapless_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_en_i && !sym_ready_o) |=> chip_valid_o);
  p_accept_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_ready_o) |=> (sym_start_o && chip_valid_o));
  p_start_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_o |-> chip_valid_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_ready_o && !sym_valid_i) |=> (!chip_valid_o && !chip_o && !sym_start_o));
  p_rem_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q < CW'(FW));
endmodule

// File: rtl/cobi_spreader.sv
module cobi_spreader
  import cobi_pkg::*;
#(
  parameter int unsigned N_LONG  = LONG_CHIPS,
  parameter int unsigned N_SHORT = SHORT_CHIPS,
  localparam int unsigned SW     = $clog2(N_LONG),
  localparam int unsigned SSW    = $clog2(N_SHORT),
  localparam int unsigned FW     = N_LONG + 1,
  localparam int unsigned CW     = $clog2(FW + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               chip_en_i,
  input  logic               sym_valid_i,
  input  logic [SW-1:0]      sym_i,
  output logic               sym_ready_o,
  input  logic               short_mode_i,
  input  logic               prefix_en_i,
  input  logic [N_LONG-1:0]  root_long_i,
  input  logic [N_SHORT-1:0] root_short_i,
  output logic               chip_o,
  output logic               chip_valid_o,
  output logic               sym_start_o
);
  logic [N_LONG-1:0]  seq_long;
  logic [N_SHORT-1:0] seq_short;
  logic [FW-1:0]      frame_raw, frame;
  logic               last_chip;
  logic [CW-1:0]      len;

  cobi_seq_gen #(.N(N_LONG)) u_gen_long (
    .root_i (root_long_i),
    .sym_i  (sym_i),
    .seq_o  (seq_long)
  );

  cobi_seq_gen #(.N(N_SHORT)) u_gen_short (
    .root_i (root_short_i),
    .sym_i  (sym_i[SSW-1:0]),
    .seq_o  (seq_short)
  );

  // left-align the chosen sequence; prefix repeats its last chip in front
  always_comb begin
    if (short_mode_i) begin
      frame_raw = FW'(seq_short) << (FW - N_SHORT);
      last_chip = seq_short[0];
      len       = CW'(N_SHORT) + CW'(prefix_en_i);
    end else begin
      frame_raw = FW'(seq_long) << (FW - N_LONG);
      last_chip = seq_long[0];
      len       = CW'(N_LONG) + CW'(prefix_en_i);
    end
    frame = prefix_en_i ? {last_chip, frame_raw[FW-1:1]} : frame_raw;
  end

  cobi_frame_ctrl #(.FW(FW), .CW(CW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chip_en_i    (chip_en_i),
    .sym_valid_i  (sym_valid_i),
    .frame_i      (frame),
    .len_i        (len),
    .sym_ready_o  (sym_ready_o),
    .chip_o       (chip_o),
    .chip_valid_o (chip_valid_o),
    .sym_start_o  (sym_start_o)
  );

  p_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_ready_o) |-> (len == (short_mode_i ? CW'(N_SHORT) : CW'(N_LONG)) + CW'(prefix_en_i)));
endmodule

// File: tb/sim_cobi_spreader.sv
module sim_cobi_spreader;
  localparam int CLK_P = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic        chip_en_i = 0, sym_valid_i = 0;
  logic [3:0]  sym_i = '0;
  logic        short_mode_i = 0, prefix_en_i = 0;
  logic [15:0] root_long_i = 16'h3AFC;
  logic [7:0]  root_short_i = 8'h45;
  logic        sym_ready_o, chip_o, chip_valid_o, sym_start_o;

  cobi_spreader u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc_n = 0;
  int pend[$];
  bit q_chip[$];
  bit q_first[$];
  string q_tag[$];
  bit exp_chip = 0, exp_valid = 0, exp_start = 0;
  string exp_tag = "R1", override = "";

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, act, expv, $time);
    end
  endtask

  function automatic bit root_chip(int j, int n);
    return short_mode_i ? root_short_i[n-1-j] : root_long_i[n-1-j];
  endfunction

  // Requirement model: chip i = base[(i-2r) mod n], base = root with optional odd-chip inversion
  function automatic void push_frame(int s);
    int n, k, r;
    bit inv;
    bit seq[$];
    string tag;
    n   = short_mode_i ? 8 : 16;
    k   = short_mode_i ? (s & 7) : (s & 15);
    inv = k >= n / 2;
    r   = 2 * (k % (n / 2));
    for (int i = 0; i < n; i++) begin
      int j;
      j = (i - r + n) % n;
      seq.push_back(root_chip(j, n) ^ (inv && (j % 2 == 1)));
    end
    if (short_mode_i) tag = "R5";
    else if (k == 0) tag = "R2";
    else if (k < 8) tag = "R3";
    else tag = "R4";
    if (prefix_en_i) begin
      q_chip.push_back(seq[n-1]); q_first.push_back(1); q_tag.push_back("R6");
    end
    for (int i = 0; i < n; i++) begin
      q_chip.push_back(seq[i]);
      q_first.push_back(!prefix_en_i && i == 0);
      q_tag.push_back(tag);
    end
  endfunction

  task automatic cyc(bit en);
    bit exp_ready;
    chip_en_i   = en;
    sym_valid_i = pend.size() > 0;
    sym_i       = sym_valid_i ? 4'(pend[0]) : 4'd0;
    #1;
    exp_ready = en && q_chip.size() == 0;
    chk(sym_ready_o == exp_ready, "R8", "sym_ready_o", sym_ready_o, exp_ready);
    if (en) begin
      if (q_chip.size() == 0 && sym_valid_i) push_frame(pend.pop_front());
      if (q_chip.size() > 0) begin
        exp_chip  = q_chip.pop_front();
        exp_start = q_first.pop_front();
        exp_tag   = q_tag.pop_front();
        exp_valid = 1;
      end else begin
        exp_chip = 0; exp_start = 0; exp_valid = 0; exp_tag = "R10";
      end
    end else exp_tag = "R7";
    if (override != "") exp_tag = override;
    @(posedge clk_i); #1;
    cyc_n++;
    chk(chip_valid_o == exp_valid, exp_tag, "chip_valid_o", chip_valid_o, exp_valid);
    chk(chip_o == exp_chip, exp_tag, "chip_o", chip_o, exp_chip);
    chk(sym_start_o == exp_start, (exp_start || sym_start_o) ? "R9" : exp_tag, "sym_start_o", sym_start_o, exp_start);
  endtask

  function automatic bit en_pat(int p);
    case (p)
      1: return (cyc_n % 3) != 2;
      2: return (cyc_n % 2) == 0;
      default: return 1;
    endcase
  endfunction

  task automatic drain(int p);
    int guard = 0;
    while ((pend.size() > 0 || q_chip.size() > 0) && guard < 2000) begin
      cyc(en_pat(p));
      guard++;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    chip_en_i = 1;
    repeat (2) @(posedge clk_i);
    #1;
    chk(chip_o == 0 && chip_valid_o == 0 && sym_start_o == 0, "R1", "outputs in reset", {chip_o, chip_valid_o, sym_start_o}, 0);
    chk(sym_ready_o == 1, "R1", "sym_ready_o in reset", sym_ready_o, 1);
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;

    // long mode, all symbols back to back
    for (int s = 0; s < 16; s++) pend.push_back(s);
    drain(0);
    repeat (2) cyc(1);   // R10 idle slots
    // long mode with prefix, sparse chip enables
    prefix_en_i = 1;
    pend = '{3, 8, 15, 0};
    drain(1);
    // short mode, sym_i[3] ignored
    short_mode_i = 1; prefix_en_i = 0;
    for (int s = 0; s < 8; s++) pend.push_back(s);
    pend.push_back(12);
    drain(0);
    prefix_en_i = 1;
    pend = '{5, 2, 15};
    drain(2);
    // gaps between symbols
    short_mode_i = 0; prefix_en_i = 0;
    pend = '{6};
    drain(0);
    repeat (3) cyc(1);
    repeat (2) cyc(0);
    pend = '{9};
    drain(0);
    // R11: configuration changes during a symbol
    pend = '{10};
    repeat (3) cyc(1);
    override = "R11";
    root_long_i = 16'd141; root_short_i = 8'd171; short_mode_i = 1; prefix_en_i = 1;
    drain(0);
    override = "";
    pend = '{2, 6};
    drain(1);
    short_mode_i = 0;
    pend = '{1, 13};
    drain(0);
    repeat (2) cyc(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule